// File: doc/BRIEF.md
# GFSK Transmit Pulse Shaper

This block turns serial transmit bits into a signed frequency-deviation word for a GFSK modulator. A strobe marks each new bit. The bit is then held and fed into a six-tap FIR once per filter clock, so a bit that lasts six filter clocks fills the whole window. The FIR has a fixed, symmetric, Gaussian-like response. Its output is scaled by a 3-bit code and registered as a deviation in units of 1 kHz.

The shaper runs only while the transmitter is on and the shaping enable is set. While it is idle it drives zero deviation, ignores strobes and empties its history. Each new enable therefore starts from a neutral window.

Top module: `gfsk_shaper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the history and drives `dev_out` to 0.
- R2: Each window sample is +1 for a one bit, −1 for a zero bit, and 0 for an empty slot. Sample k is weighted by 22, 67, 111, 111, 67, 22 for k = 0..5, where sample 0 is the newest. The weights sum to 400.
- R3: When `smp_stb` is high during an active clock, `tx_bit` is captured as the new sample. On active clocks without the strobe, the last captured sample is fed again.
- R4: The registered output at an active edge already includes the sample taken at that edge. After six edges with the same bit, the unscaled sum is +400 for ones and −400 for zeros.
- R5: `dev_out` = (sum × (6 + `dev_scale`)) / 10, truncated toward zero. Code 0 gives 60 % and code 7 gives 130 %, in 10 % steps.
- R6: When `tx_on` and `shp_en` are not both 1 at an edge, `dev_out` becomes 0 at that edge, the strobe and the data are ignored, and the history is emptied.
- R7: After the shaper becomes active again, the output is 0 until a strobe delivers a bit. The first bit then gives 22 × scale, because only the newest slot is filled.
- R8: The magnitude of `dev_out` never exceeds 520, which is 400 at 130 %.
- R9: A change of `dev_scale` takes effect in the output registered at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_on | input | 1 | Transmitter active |
| shp_en | input | 1 | Shaping enable control bit |
| smp_stb | input | 1 | Marks a new bit on `tx_bit` |
| tx_bit | input | 1 | Serial transmit data |
| dev_scale | input | 3 | Deviation scale code, 60 % + 10 % × code |
| dev_out | output | 16 | Signed deviation in kHz, registered |

## Verification
A stale or misordered history slot shows at the ports on the very next edge. It produces a partial sum that does not match the 22/89/200/311/378/400 ramp a fresh run of equal bits must trace. A history that is not emptied on disable shows on the first active edge after re-enable as a nonzero output where 0 is expected. A wrong scale factor shows in the first registered word after a steady run or after a code change.

// File: rtl/gfsk_shp_pkg.sv
package gfsk_shp_pkg;

  localparam int NTAPS = 6;

  // sample encoding inside the window
  localparam logic [1:0] SMP_NONE = 2'b00;
  localparam logic [1:0] SMP_POS  = 2'b01;
  localparam logic [1:0] SMP_NEG  = 2'b11;

  // symmetric Gaussian-like weights, newest sample first
  function automatic int tap_coef(input int idx);
    case (idx)
      0, 5:    return 22;
      1, 4:    return 67;
      default: return 111;
    endcase
  endfunction

  function automatic int coef_total();
    int acc;
    acc = 0;
    for (int i = 0; i < NTAPS; i++) acc += tap_coef(i);
    return acc;
  endfunction

  // percent scale 60 + 10*code, truncating toward zero
  function automatic int scaled_dev(input int fir_sum, input int code);
    return (fir_sum * (code + 6)) / 10;
  endfunction

  localparam int FULL_SUM = coef_total();
  localparam int PEAK_DEV = scaled_dev(FULL_SUM, 7);

endpackage

// File: rtl/gfsk_tap_line.sv
module gfsk_tap_line
  import gfsk_shp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    active,
  input  logic                    stb,
  input  logic                    bit_in,
  output logic [NTAPS-1:0][1:0]   win,
  output logic                    line_empty,
  output logic                    win_all_pos
);

  logic [1:0]             hold_q;
  logic [NTAPS-2:0][1:0]  dly_q;
  logic [1:0]             cur_smp;

  assign cur_smp = stb ? (bit_in ? SMP_POS : SMP_NEG) : hold_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      hold_q <= SMP_NONE;
      dly_q  <= '0;
    end else begin
      hold_q <= cur_smp;
      dly_q  <= {dly_q[NTAPS-3:0], cur_smp};
    end
  end

  assign win[0] = cur_smp;
  for (genvar g = 1; g < NTAPS; g++) begin : g_win
    assign win[g] = dly_q[g-1];
  end

  assign line_empty = (hold_q == SMP_NONE) && (dly_q == '0);

  always_comb begin
    win_all_pos = 1'b1;
    for (int i = 0; i < NTAPS; i++)
      if (win[i] != SMP_POS) win_all_pos = 1'b0;
  end

  AST_HOLD_REPEAT: assert property (@(posedge clk) disable iff (rst)
    active ##1 (active && !stb) |-> (cur_smp == $past(cur_smp))); // R3

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !active |=> line_empty); // R6

endmodule

// File: rtl/gfsk_fir_sum.sv
module gfsk_fir_sum
  import gfsk_shp_pkg::*;
#(
  parameter int SUM_W = 11
)(
  input  logic [NTAPS-1:0][1:0]     win,
  output logic signed [SUM_W-1:0]   fir_sum
);

  logic signed [SUM_W-1:0] term [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_term
    localparam logic signed [SUM_W-1:0] CW = SUM_W'(tap_coef(g));
    always_comb begin
      case (win[g])
        SMP_POS: term[g] = CW;
        SMP_NEG: term[g] = -CW;
        default: term[g] = '0;
      endcase
    end
  end

  always_comb begin
    fir_sum = '0;
    for (int i = 0; i < NTAPS; i++) fir_sum = fir_sum + term[i];
  end

endmodule

// File: rtl/gfsk_dev_scale.sv
module gfsk_dev_scale
  import gfsk_shp_pkg::*;
#(
  parameter int SUM_W  = 11,
  parameter int CODE_W = 3,
  parameter int DEV_W  = 16
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic signed [SUM_W-1:0]  fir_sum,
  input  logic [CODE_W-1:0]        code,
  output logic signed [DEV_W-1:0]  dev_out
);

  localparam logic signed [DEV_W-1:0] PEAK = DEV_W'(PEAK_DEV);

  logic signed [DEV_W-1:0] dev_d;

  assign dev_d = DEV_W'(scaled_dev(int'(fir_sum), int'(code)));

  always_ff @(posedge clk) begin
    if (rst || !active) dev_out <= '0;
    else                dev_out <= dev_d;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |=> (dev_out == '0)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dev_out <= PEAK) && (dev_out >= -PEAK)); // R8

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (active && fir_sum > 0) |=> (dev_out > 0)); // R5

endmodule

// File: rtl/gfsk_shaper.sv
module gfsk_shaper
  import gfsk_shp_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int DEV_W  = 16,
  parameter int SUM_W  = 11
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_on,
  input  logic                     shp_en,
  input  logic                     smp_stb,
  input  logic                     tx_bit,
  input  logic [CODE_W-1:0]        dev_scale,
  output logic signed [DEV_W-1:0]  dev_out
);

  logic                     active;
  logic [NTAPS-1:0][1:0]    win;
  logic                     line_empty;
  logic                     win_all_pos;
  logic signed [SUM_W-1:0]  fir_sum;

  assign active = tx_on & shp_en;

  gfsk_tap_line u_line (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .stb         (smp_stb),
    .bit_in      (tx_bit),
    .win         (win),
    .line_empty  (line_empty),
    .win_all_pos (win_all_pos)
  );

  gfsk_fir_sum #(.SUM_W(SUM_W)) u_sum (
    .win     (win),
    .fir_sum (fir_sum)
  );

  gfsk_dev_scale #(.SUM_W(SUM_W), .CODE_W(CODE_W), .DEV_W(DEV_W)) u_scale (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .fir_sum (fir_sum),
    .code    (dev_scale),
    .dev_out (dev_out)
  );

  AST_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    win_all_pos |-> (fir_sum == SUM_W'(FULL_SUM))); // R4

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (line_empty && active && !smp_stb) |=> (dev_out == '0)); // R7

endmodule

// File: tb/gfsk_shaper_test.sv
module gfsk_shaper_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               tx_on = 1'b0;
  logic               shp_en = 1'b0;
  logic               smp_stb = 1'b0;
  logic               tx_bit = 1'b0;
  logic [2:0]         dev_scale = 3'd4;
  logic signed [15:0] dev_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int cyc = 0;

  int win_m [6];
  int hold_m = 0;
  int exp_dev = 0;
  int wts [6] = '{22, 67, 111, 111, 67, 22};

  gfsk_shaper uut (
    .clk(clk), .rst(rst), .tx_on(tx_on), .shp_en(shp_en),
    .smp_stb(smp_stb), .tx_bit(tx_bit), .dev_scale(dev_scale),
    .dev_out(dev_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // model of the requirements, updated at each rising edge
  task automatic model_edge(input logic stb, input logic b);
    int cur, s;
    if (rst || !(tx_on && shp_en)) begin
      for (int i = 0; i < 6; i++) win_m[i] = 0;
      hold_m = 0;
      exp_dev = 0;
    end else begin
      cur = stb ? (b ? 1 : -1) : hold_m;
      for (int i = 5; i > 0; i--) win_m[i] = win_m[i-1];
      win_m[0] = cur;
      hold_m = cur;
      s = 0;
      for (int i = 0; i < 6; i++) s += wts[i] * win_m[i];
      exp_dev = (s * (int'(dev_scale) + 6)) / 10;
    end
  endtask

  task automatic tick(input logic stb, input logic b, input string req);
    smp_stb = stb; tx_bit = b;
    @(posedge clk);
    model_edge(stb, b);
    #2;
    check(req, int'(dev_out), exp_dev);
  endtask

  task automatic send_bit(input logic b, input int len, input string req);
    tick(1'b1, b, req);
    for (int i = 1; i < len; i++) tick(1'b0, b, req);
  endtask

  task automatic t_reset();
    rst = 1; tx_on = 1; shp_en = 1;
    tick(1'b1, 1'b1, "R1");
    tick(1'b1, 1'b0, "R1");
    check("R1", int'(dev_out), 0);
    rst = 0;
    tick(1'b0, 1'b0, "R1"); // history empty: still 0
    check("R1", int'(dev_out), 0);
  endtask

  task automatic t_ramp_ones();
    int ramp [6] = '{22, 89, 200, 311, 378, 400};
    dev_scale = 3'd4;
    for (int k = 0; k < 6; k++) begin
      tick(k == 0, 1'b1, "R4");
      check("R2", int'(dev_out), ramp[k]);
    end
    tick(1'b0, 1'b1, "R4");
    check("R4", int'(dev_out), 400);
  endtask

  task automatic t_alternate();
    dev_scale = 3'd0;
    send_bit(1'b0, 6, "R2");
    send_bit(1'b1, 6, "R3");
    send_bit(1'b0, 3, "R3");
    send_bit(1'b1, 1, "R3");
    send_bit(1'b0, 1, "R3");
    send_bit(1'b1, 6, "R5");
  endtask

  task automatic t_scale_sweep();
    for (int c = 0; c < 8; c++) begin
      dev_scale = 3'(c);
      send_bit(1'b0, 6, "R5");
      check("R5", int'(dev_out), -(400 * (c + 6)) / 10);
    end
    check("R8", int'(dev_out), -520);
  endtask

  task automatic t_code_step();
    dev_scale = 3'd7;
    send_bit(1'b1, 6, "R9");
    check("R8", int'(dev_out), 520);
    dev_scale = 3'd2;
    tick(1'b0, 1'b1, "R9");
    check("R9", int'(dev_out), 320);
    dev_scale = 3'd5;
    tick(1'b0, 1'b1, "R9");
    check("R9", int'(dev_out), 440);
  endtask

  task automatic t_disable();
    dev_scale = 3'd4;
    shp_en = 0;
    tick(1'b1, 1'b0, "R6");
    check("R6", int'(dev_out), 0);
    tick(1'b1, 1'b1, "R6");
    shp_en = 1; tx_on = 0;
    tick(1'b1, 1'b0, "R6");
    check("R6", int'(dev_out), 0);
    tx_on = 1;
  endtask

  task automatic t_reenable();
    tick(1'b0, 1'b1, "R7");
    check("R7", int'(dev_out), 0);
    tick(1'b0, 1'b0, "R7");
    tick(1'b1, 1'b1, "R7");
    check("R7", int'(dev_out), 22);
    tick(1'b0, 1'b1, "R7");
    check("R7", int'(dev_out), 89);
  endtask

  initial begin
    t_reset();
    t_ramp_ones();
    t_alternate();
    t_scale_sweep();
    t_code_step();
    t_disable();
    t_reenable();
    rst = 1;
    tick(1'b0, 1'b0, "R1");
    check("R1", int'(dev_out), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule